// File: doc/BRIEF.md
# Instrument Status Summary Unit

This unit keeps the status-reporting state of a remotely programmed instrument. Hardware pulses for operation complete, query error, device fault, execution error and command error set sticky bits in a standard event register. A power-on bit in that register is set once, when the unit leaves reset. Three live condition inputs also feed a summary status byte: error queue not empty, questionable summary and operational summary.

A host reaches the unit over a small register bus with a 2-bit address. The status byte is only a view of the current state, so reading it changes nothing. The event register is cleared by reading it. Two enable masks decide which bits feed the status-byte summaries. A separate clear-status strobe empties the event register and sends a one-cycle flush request to the external error queue.

`bus_rdata` always shows the register selected by `bus_addr`, with no delay. `bus_rd` matters only at address 1, where it clears the event register on the clock edge.

Top module: `istat_unit`

## Requirements
- R1: Reading the status byte (address 0) with `bus_rd` high leaves the event register and both masks unchanged.
- R2: Status byte bits 0, 1 and 4 always read 0. Bit 2 equals `errq_nonempty`, bit 3 equals `ques_sum` and bit 7 equals `oper_sum`, in the same cycle.
- R3: Status byte bit 5 is the OR of (event register AND event enable mask).
- R4: Status byte bit 6 is the OR of (status byte bits 0–5 and 7, each ANDed with the service-request mask).
- R5: A write to address 2 loads the service-request mask with only bits 2, 3, 5 and 7 of the data kept (mask 0xAC). Writing 0xFF reads back 0xAC.
- R6: A write to address 3 loads all 8 bits of the event enable mask, which reads back unchanged.
- R7: Event register layout: bit 0 operation complete, bit 2 query error, bit 3 device fault, bit 4 execution error, bit 5 command error, bit 7 power-on. A pulse sets its bit from the next cycle on. Bits 1 and 6 always read 0.
- R8: Event bits stay set until a read of address 1 or a clear-status strobe. Such a read returns the value held before the clear.
- R9: An event pulse in the same cycle as a read-clear or clear-status strobe is still set after the clear.
- R10: `clr_status` clears the event register and raises `err_flush` for exactly the following cycle. It leaves both masks unchanged.
- R11: After reset both masks read 0 and the event register reads 0x80 (power-on only). Power-on is never set again until the next reset.
- R12: Address map: 0 status byte, 1 event register, 2 service-request mask, 3 event enable mask. Writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_op_done | input | 1 | Operation-complete event pulse |
| ev_query_err | input | 1 | Query-error event pulse |
| ev_dev_fault | input | 1 | Device-fault event pulse |
| ev_exec_err | input | 1 | Execution-error event pulse |
| ev_cmd_err | input | 1 | Command-error event pulse |
| errq_nonempty | input | 1 | Error queue holds at least one entry |
| ques_sum | input | 1 | Questionable summary condition |
| oper_sum | input | 1 | Operational summary condition |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the event register at address 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Selected register contents |
| clr_status | input | 1 | Clear-status strobe |
| err_flush | output | 1 | One-cycle flush request to the error queue |

## Verification
Several properties are checked on every cycle:
- Event capture and stickiness.
- Clearing of the event register.
- Mask write filtering and holding.
- The flush pulse following the clear strobe.
- The reserved status-byte zeros.
- Status-byte reads having no side effect.

The summary bits depend on the mask contents and the live conditions together, and events can collide with clears. Those cases are shown only by the bench's scenarios, which compare every read value against an independent model.

// File: rtl/istat_pkg.sv
package istat_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  // event register bit positions
  localparam int EV_OPC  = 0;
  localparam int EV_QERR = 2;
  localparam int EV_DEV  = 3;
  localparam int EV_EXE  = 4;
  localparam int EV_CMD  = 5;
  localparam int EV_PON  = 7;

  // status byte bit positions
  localparam int SB_ERRQ = 2;
  localparam int SB_QUES = 3;
  localparam int SB_EVT  = 5;
  localparam int SB_MSS  = 6;
  localparam int SB_OPER = 7;

  localparam logic [DW-1:0] EV_VALID   = 8'hBD;
  localparam logic [DW-1:0] EV_RST_VAL = 8'h80;
  localparam logic [DW-1:0] SRE_WMASK  = 8'hAC;
  localparam logic [DW-1:0] ESE_WMASK  = 8'hFF;

  typedef enum logic [AW-1:0] {
    A_STB = 2'd0,
    A_EVT = 2'd1,
    A_SRE = 2'd2,
    A_ESE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/istat_event_reg.sv
module istat_event_reg
  import istat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_in,
  input  logic          clr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] ev_d;
  logic [DW-1:0] ev_q;
  logic [DW-1:0] ev_masked;

  assign ev_masked = ev_in & EV_VALID;

  always_comb begin
    ev_d = ev_q;
    if (clr) ev_d = '0;
    ev_d = ev_d | ev_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= EV_RST_VAL;
    else        ev_q <= ev_d;
  end

  assign q = ev_q;

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && |ev_masked) |=> ((q & $past(ev_masked)) == $past(ev_masked))); // R7
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !clr) |=> ((q & $past(q)) == $past(q))); // R8
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && clr && ev_in == '0) |=> (q == '0)); // R10
endmodule

// File: rtl/istat_mask_reg.sv
module istat_mask_reg
  import istat_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] m_d;
  logic [DW-1:0] m_q;

  always_comb begin
    m_d = m_q;
    if (we) m_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= '0;
    else        m_q <= m_d;
  end

  assign q = m_q;

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && we) |=> (q == ($past(wdata) & WMASK))); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !we) |=> $stable(q)); // R10
endmodule

// File: rtl/istat_summary.sv
module istat_summary
  import istat_pkg::*;
(
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] ese,
  input  logic [DW-1:0] sre,
  input  logic          errq,
  input  logic          ques,
  input  logic          oper,
  output logic [DW-1:0] stb
);
  logic [DW-1:0] base;

  always_comb begin
    base          = '0;
    base[SB_ERRQ] = errq;
    base[SB_QUES] = ques;
    base[SB_EVT]  = |(evt & ese);
    base[SB_OPER] = oper;
    stb           = base;
    stb[SB_MSS]   = |(base & sre & ~(DW'(1) << SB_MSS));
  end
endmodule

// File: rtl/istat_unit.sv
module istat_unit
  import istat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_op_done,
  input  logic          ev_query_err,
  input  logic          ev_dev_fault,
  input  logic          ev_exec_err,
  input  logic          ev_cmd_err,
  input  logic          errq_nonempty,
  input  logic          ques_sum,
  input  logic          oper_sum,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          clr_status,
  output logic          err_flush
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [DW-1:0] ev_vec;
  logic [DW-1:0] evt_q, sre_q, ese_q, stb;
  logic          evt_clr, sre_we, ese_we;
  logic          flush_d, flush_q;

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_OPC]  = ev_op_done;
    ev_vec[EV_QERR] = ev_query_err;
    ev_vec[EV_DEV]  = ev_dev_fault;
    ev_vec[EV_EXE]  = ev_exec_err;
    ev_vec[EV_CMD]  = ev_cmd_err;
  end

  assign evt_clr = clr_status | (bus_rd & (bus_addr == A_EVT));
  assign sre_we  = bus_wr & (bus_addr == A_SRE);
  assign ese_we  = bus_wr & (bus_addr == A_ESE);

  istat_event_reg u_evt (
    .clk(clk), .rst_n(rst_int_n), .ev_in(ev_vec), .clr(evt_clr), .q(evt_q)
  );

  istat_mask_reg #(.WMASK(SRE_WMASK)) u_sre (
    .clk(clk), .rst_n(rst_int_n), .we(sre_we), .wdata(bus_wdata), .q(sre_q)
  );

  istat_mask_reg #(.WMASK(ESE_WMASK)) u_ese (
    .clk(clk), .rst_n(rst_int_n), .we(ese_we), .wdata(bus_wdata), .q(ese_q)
  );

  istat_summary u_sum (
    .evt(evt_q), .ese(ese_q), .sre(sre_q),
    .errq(errq_nonempty), .ques(ques_sum), .oper(oper_sum), .stb(stb)
  );

  always_comb begin
    unique case (bus_addr)
      A_STB:   bus_rdata = stb;
      A_EVT:   bus_rdata = evt_q;
      A_SRE:   bus_rdata = sre_q;
      default: bus_rdata = ese_q;
    endcase
  end

  assign flush_d = clr_status;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flush_q <= 1'b0;
    else            flush_q <= flush_d;
  end
  assign err_flush = flush_q;

  AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rst_int_n && clr_status) |=> err_flush); // R10
  AST_STB_RESERVED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == A_STB) |-> (bus_rdata[0] == 1'b0 && bus_rdata[1] == 1'b0 && bus_rdata[4] == 1'b0)); // R2
  AST_STB_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rst_int_n && bus_rd && !bus_wr && bus_addr == A_STB && !clr_status && ev_vec == '0)
      |=> ($stable(evt_q) && $stable(sre_q) && $stable(ese_q))); // R1
endmodule

// File: tb/istat_unit_bench.sv
module istat_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_op_done, ev_query_err, ev_dev_fault, ev_exec_err, ev_cmd_err;
  logic       errq_nonempty, ques_sum, oper_sum;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       clr_status;
  logic       err_flush;

  always #10 clk = ~clk;

  istat_unit u_istat_unit (
    .clk(clk), .rst_n(rst_n),
    .ev_op_done(ev_op_done), .ev_query_err(ev_query_err), .ev_dev_fault(ev_dev_fault),
    .ev_exec_err(ev_exec_err), .ev_cmd_err(ev_cmd_err),
    .errq_nonempty(errq_nonempty), .ques_sum(ques_sum), .oper_sum(oper_sum),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clr_status(clr_status), .err_flush(err_flush)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] m_ev, m_sre, m_ese;
  logic       m_flush;

  function automatic logic [7:0] model_stb(input logic eq, input logic qs, input logic op);
    logic [7:0] b;
    b    = 8'h00;
    b[2] = eq;
    b[3] = qs;
    b[5] = |(m_ev & m_ese);
    b[7] = op;
    b[6] = |(b & m_sre);
    return b;
  endfunction

  function automatic logic [7:0] model_rd(input logic [1:0] a, input logic eq,
                                          input logic qs, input logic op);
    case (a)
      2'd0:    return model_stb(eq, qs, op);
      2'd1:    return m_ev;
      2'd2:    return m_sre;
      default: return m_ese;
    endcase
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // evs order: {cmd, exe, dev, qerr, opc}
  task automatic step(input string req, input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd, input logic [4:0] evs, input logic clr,
                      input logic eq, input logic qs, input logic op);
    logic [7:0] evv;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    {ev_cmd_err, ev_exec_err, ev_dev_fault, ev_query_err, ev_op_done} = evs;
    clr_status = clr; errq_nonempty = eq; ques_sum = qs; oper_sum = op;
    #1;
    check8(req, bus_rdata, model_rd(a, eq, qs, op));
    check8("R10 flush", {7'd0, err_flush}, {7'd0, m_flush});
    evv = {2'b00, evs[4], evs[3], evs[2], evs[1], 1'b0, evs[0]};
    if (clr || (rd && a == 2'd1)) m_ev = 8'h00;
    m_ev = m_ev | evv;
    if (wr && a == 2'd2) m_sre = wd & 8'hAC;
    if (wr && a == 2'd3) m_ese = wd;
    m_flush = clr;
  endtask

  task automatic idle();
    step("idle", 1'b0, 1'b0, 2'd0, 8'h00, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    {ev_cmd_err, ev_exec_err, ev_dev_fault, ev_query_err, ev_op_done} = 5'd0;
    clr_status = 0; errq_nonempty = 0; ques_sum = 0; oper_sum = 0;
    m_ev = 8'h80; m_sre = 0; m_ese = 0; m_flush = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    step("R11 sre reset", 0, 0, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R11 ese reset", 0, 0, 2'd3, 0, 0, 0, 0, 0, 0);
    step("R11 pon at reset", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    // R5 / R6 masks
    step("R5 write sre ff", 0, 1, 2'd2, 8'hFF, 0, 0, 0, 0, 0);
    step("R5 sre reads ac", 0, 0, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R6 write ese", 0, 1, 2'd3, 8'h5A, 0, 0, 0, 0, 0);
    step("R6 ese readback", 0, 0, 2'd3, 0, 0, 0, 0, 0, 0);
    // R12 writes to 0 and 1 ignored
    step("R12 write stb", 0, 1, 2'd0, 8'hFF, 0, 0, 0, 0, 0);
    step("R12 write evt", 0, 1, 2'd1, 8'h7F, 0, 0, 0, 0, 0);
    step("R12 evt unchanged", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    // R1 status read has no side effect
    step("R1 stb read", 1, 0, 2'd0, 0, 0, 0, 1, 0, 0);
    step("R1 evt after stb read", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    // R8 / R11 read clears, pon only once
    step("R8 read returns old", 1, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    step("R11 pon not reset", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    // R7 each event position
    for (int i = 0; i < 5; i++) begin
      step("R7 pulse", 0, 0, 2'd1, 0, 5'(1 << i), 0, 0, 0, 0);
      step("R7 bit set", 1, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    end
    // R2 / R4 conditions with sre=ac
    step("R2 errq", 0, 0, 2'd0, 0, 0, 0, 1, 0, 0);
    step("R2 ques", 0, 0, 2'd0, 0, 0, 0, 0, 1, 0);
    step("R2 oper", 0, 0, 2'd0, 0, 0, 0, 0, 0, 1);
    step("R4 mss off", 0, 1, 2'd2, 8'h00, 0, 0, 0, 0, 1);
    step("R4 mss masked", 0, 0, 2'd0, 0, 0, 0, 1, 1, 1);
    // R3 event summary
    step("R3 ese all", 0, 1, 2'd3, 8'hFF, 5'b10000, 0, 0, 0, 0);
    step("R3 evt summary", 0, 0, 2'd0, 0, 0, 0, 0, 0, 0);
    // R9 event collides with read-clear
    step("R9 read with event", 1, 0, 2'd1, 0, 5'b00010, 0, 0, 0, 0);
    step("R9 survived", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    step("R9 clr with event", 0, 0, 2'd1, 0, 5'b00001, 1, 0, 0, 0);
    step("R9 survived clr", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);
    // R10 clear keeps masks
    step("R10 set sre", 0, 1, 2'd2, 8'hA4, 5'b01000, 0, 0, 0, 0);
    step("R10 clr", 0, 0, 2'd2, 0, 0, 1, 0, 0, 0);
    step("R10 sre kept", 0, 0, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R10 ese kept", 0, 0, 2'd3, 0, 0, 0, 0, 0, 0);
    step("R10 evt cleared", 0, 0, 2'd1, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R12 random", r[0] & r[1], r[2] & r[3] & ~(r[0] & r[1]), r[5:4], r[13:6],
           ((r[18:14] & r[23:19]) & {5{r[24]}}), (r[27:25] == 3'd0), r[28], r[29], r[30]);
    end

    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule